// File: doc/BRIEF.md
# Ferroelectric RAM Device Model with Protocol Checking

This block is a synthesizable, clocked stand-in for the memory side of a bytewide nonvolatile ferroelectric RAM. It is meant for testing memory controllers. A fast sample clock samples the active-low chip enable, output enable and write enable pins. The block also samples the 13-bit address and the write byte. It keeps the bytes in an internal array and shows read data only after the chip-enable access delay has passed.

Every nanosecond limit is a parameter and is turned into a count of sample clocks. The block watches the controller for breaks of the pin protocol: short precharge, short active time, short cycle, short write pulse, and write enable together with output enable. Each break sets a sticky flag, and the flag stays set until a synchronous clear is pulsed. The block also counts every access against its 8-byte row, so that endurance hot spots are visible. The most-accessed row and its count are outputs.

Top module: `fram_model`

## Requirements
- R1: The address is captured at the sample where chip enable is first seen low. Address changes later in the same low period affect neither a read nor the location written.
- R2: If chip enable falls after being high for fewer than 60 ns worth of samples (12 at the default 5 ns period), `pc_viol_o` is set. Exactly 12 high samples does not set it.
- R3: If chip enable stays low for fewer than 70 ns of samples (14), `ca_viol_o` is set when it rises. If the time from one falling edge to the next is shorter than 130 ns (26 samples), `rc_viol_o` is set.
- R4: A write-enable low pulse shorter than 40 ns (8 samples) sets `wp_viol_o`. The byte that is present while both strobes are low is stored once both strobes are high again. Writes ended by write enable and writes ended by chip enable are both stored.
- R5: Each chip-enable falling edge adds one count to the row given by address bits [12:3]. `hot_row_o` and `hot_cnt_o` show the row whose count first went strictly above the previous maximum.
- R6: `rdata_en_o` is 1, and `rdata_o` shows the stored byte, only while chip enable and output enable are low and chip enable has been low for at least 70 ns (14 samples). Otherwise `rdata_en_o` is 0 and `rdata_o` is 0. Data is released one sample after chip enable or output enable goes high.
- R7: All violation flags are 0 after reset. They stay set until `clr_i` is sampled high, and `clr_i` clears all of them.
- R8: Row counters saturate at 2^CNT_W-1 (255 by default) and do not wrap.
- R9: If chip enable, output enable and write enable are all low in the same sample, `bus_conflict_o` is set. The write wins: no read data is shown during that access, and the byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 8 | Write byte |
| clr_i | input | 1 | Synchronous clear of the violation flags |
| rdata_o | output | 8 | Read byte, 0 when not driven |
| rdata_en_o | output | 1 | Read data valid (stands in for the output driver) |
| pc_viol_o | output | 1 | Precharge too short |
| ca_viol_o | output | 1 | Chip-enable low time too short |
| rc_viol_o | output | 1 | Cycle time too short |
| wp_viol_o | output | 1 | Write pulse too short |
| bus_conflict_o | output | 1 | Write enable and output enable low together |
| hot_row_o | output | 10 | Index of the most-accessed row |
| hot_cnt_o | output | 8 | Access count of that row |

## Verification
The hardest condition to reach from the ports is counter saturation. It needs hundreds of complete, protocol-legal accesses to one row, with no faster path to get there. The bench gets there by looping over several hundred minimum-length reads that all use addresses inside one row. It keeps its own count of every row to predict the hot-row outputs. Timing violations are separated from each other by choosing high and low times one sample either side of each limit. This way the precharge, active-time and cycle flags are each shown to set on their own or together as the arithmetic requires.

// File: rtl/fram_pkg.sv
`timescale 1ns/1ps
package fram_pkg;
  typedef struct packed {
    logic pc;
    logic ca;
    logic rc;
    logic wp;
    logic bus;
  } viol_t;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction
endpackage

// File: rtl/fram_timing.sv
`timescale 1ns/1ps
module fram_timing
  import fram_pkg::*;
#(
  parameter int unsigned CLK_NS  = 5,
  parameter int unsigned T_PC_NS = 60,
  parameter int unsigned T_CA_NS = 70,
  parameter int unsigned T_RC_NS = 130,
  parameter int unsigned T_WP_NS = 40,
  parameter int unsigned T_CE_NS = 70
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  we_ni,
  input  logic  clr_i,
  output logic  ce_fall_o,
  output logic  oe_q_o,
  output logic  we_q_o,
  output logic  ready_o,
  output viol_t viol_o
);
  localparam int unsigned PC_CYC = ns2cyc(T_PC_NS, CLK_NS);
  localparam int unsigned CA_CYC = ns2cyc(T_CA_NS, CLK_NS);
  localparam int unsigned RC_CYC = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned WP_CYC = ns2cyc(T_WP_NS, CLK_NS);
  localparam int unsigned CE_CYC = ns2cyc(T_CE_NS, CLK_NS);
  localparam int unsigned MAXC   = (RC_CYC > CE_CYC) ? RC_CYC : CE_CYC;
  localparam int unsigned CW     = $clog2(MAXC + 2);

  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t CMAX = '1;

  cnt_t hi_cnt, lo_cnt, cyc_cnt, wl_cnt;
  logic ce_q, oe_q, we_q;
  logic ce_fall, ce_rise, we_fall, we_rise;

  function automatic cnt_t sat_inc(cnt_t v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  assign ce_fall = ce_q & ~ce_ni;
  assign ce_rise = ~ce_q & ce_ni;
  assign we_fall = we_q & ~we_ni;
  assign we_rise = ~we_q & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      hi_cnt  <= CMAX;   // first access after reset is never a precharge break
      lo_cnt  <= '0;
      cyc_cnt <= CMAX;
      wl_cnt  <= '0;
      viol_o  <= '0;
    end else begin
      ce_q <= ce_ni;
      oe_q <= oe_ni;
      we_q <= we_ni;

      if (ce_rise)             hi_cnt <= cnt_t'(1);
      else if (ce_q && ce_ni)  hi_cnt <= sat_inc(hi_cnt);

      if (ce_fall)             lo_cnt <= cnt_t'(1);
      else if (!ce_q && !ce_ni) lo_cnt <= sat_inc(lo_cnt);

      cyc_cnt <= ce_fall ? cnt_t'(1) : sat_inc(cyc_cnt);

      if (we_fall)             wl_cnt <= cnt_t'(1);
      else if (!we_q && !we_ni) wl_cnt <= sat_inc(wl_cnt);

      if (clr_i) begin
        viol_o <= '0;
      end else begin
        if (ce_fall && hi_cnt  < cnt_t'(PC_CYC)) viol_o.pc <= 1'b1;
        if (ce_fall && cyc_cnt < cnt_t'(RC_CYC)) viol_o.rc <= 1'b1;
        if (ce_rise && lo_cnt  < cnt_t'(CA_CYC)) viol_o.ca <= 1'b1;
        if (we_rise && wl_cnt  < cnt_t'(WP_CYC)) viol_o.wp <= 1'b1;
        if (!ce_ni && !oe_ni && !we_ni)          viol_o.bus <= 1'b1;
      end
    end
  end

  assign ce_fall_o = ce_fall;
  assign oe_q_o    = oe_q;
  assign we_q_o    = we_q;
  assign ready_o   = ~ce_q & (lo_cnt >= cnt_t'(CE_CYC));
endmodule

// File: rtl/fram_array.sv
`timescale 1ns/1ps
module fram_array #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              ce_fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              pend;
  logic              commit;

  // store once both strobes are released (the later rise)
  assign commit = pend & ce_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      pend    <= 1'b0;
    end else begin
      if (ce_fall_i) addr_q <= addr_i;
      if (!ce_ni && !we_ni) begin
        pend    <= 1'b1;
        wdata_q <= wdata_i;
      end else if (commit) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit) mem[addr_q] <= wdata_q;
  end

  assign rdata_o  = rd_en_i ? mem[addr_q] : '0;
  assign addr_q_o = addr_q;
endmodule

// File: rtl/fram_endurance.sv
`timescale 1ns/1ps
module fram_endurance #(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [ROW_W-1:0] hot_row_o,
  output logic [CNT_W-1:0] hot_cnt_o
);
  localparam int unsigned ROWS = 1 << ROW_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt [ROWS];
  logic [CNT_W-1:0] cur, nxt;

  assign cur = cnt[row_i];
  assign nxt = (cur == CMAX) ? cur : cur + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS; i++) cnt[i] <= '0;
      hot_row_o <= '0;
      hot_cnt_o <= '0;
    end else if (hit_i) begin
      cnt[row_i] <= nxt;
      if (nxt > hot_cnt_o) begin
        hot_row_o <= row_i;
        hot_cnt_o <= nxt;
      end
    end
  end
endmodule

// File: rtl/fram_model.sv
`timescale 1ns/1ps
module fram_model
  import fram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ROW_BYTES = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned T_PC_NS   = 60,
  parameter int unsigned T_CA_NS   = 70,
  parameter int unsigned T_RC_NS   = 130,
  parameter int unsigned T_WP_NS   = 40,
  parameter int unsigned T_CE_NS   = 70,
  localparam int unsigned COL_W    = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W    = ADDR_W - COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_en_o,
  output logic              pc_viol_o,
  output logic              ca_viol_o,
  output logic              rc_viol_o,
  output logic              wp_viol_o,
  output logic              bus_conflict_o,
  output logic [ROW_W-1:0]  hot_row_o,
  output logic [CNT_W-1:0]  hot_cnt_o
);
  logic              ce_fall, oe_q, we_q, ready;
  logic [ADDR_W-1:0] addr_lat;
  viol_t             viol;

  fram_timing #(
    .CLK_NS(CLK_NS), .T_PC_NS(T_PC_NS), .T_CA_NS(T_CA_NS),
    .T_RC_NS(T_RC_NS), .T_WP_NS(T_WP_NS), .T_CE_NS(T_CE_NS)
  ) u_timing (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .clr_i,
    .ce_fall_o(ce_fall), .oe_q_o(oe_q), .we_q_o(we_q),
    .ready_o(ready), .viol_o(viol)
  );

  // write wins over read when both strobes are low
  assign rdata_en_o = ready & ~oe_q & we_q;

  fram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni, .ce_ni, .we_ni,
    .ce_fall_i(ce_fall), .addr_i, .wdata_i,
    .rd_en_i(rdata_en_o), .rdata_o, .addr_q_o(addr_lat)
  );

  fram_endurance #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_endur (
    .clk_i, .rst_ni, .hit_i(ce_fall), .row_i(addr_i[ADDR_W-1:COL_W]),
    .hot_row_o, .hot_cnt_o
  );

  assign pc_viol_o      = viol.pc;
  assign ca_viol_o      = viol.ca;
  assign rc_viol_o      = viol.rc;
  assign wp_viol_o      = viol.wp;
  assign bus_conflict_o = viol.bus;
endmodule

// File: rtl/fram_model_chk.sv
`timescale 1ns/1ps
module fram_model_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              clr_i,
  input logic              rdata_en_o,
  input logic              pc_viol_o,
  input logic              ca_viol_o,
  input logic              wp_viol_o,
  input logic              bus_conflict_o,
  input logic [CNT_W-1:0]  hot_cnt_o,
  input logic [ADDR_W-1:0] addr_lat
);
  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(ce_ni) && !ce_ni) |=> $stable(addr_lat));

  assert_rd_strobes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_en_o |-> $past(!ce_ni && !oe_ni));

  assert_hot_mono_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hot_cnt_o >= $past(hot_cnt_o));

  assert_pc_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_viol_o && !clr_i) |=> pc_viol_o);

  assert_ca_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ca_viol_o && !clr_i) |=> ca_viol_o);

  assert_wp_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_viol_o && !clr_i) |=> wp_viol_o);

  assert_conflict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !we_ni && !clr_i) |=> bus_conflict_o);

  assert_write_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_en_o |-> $past(we_ni));
endmodule

bind fram_model fram_model_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .clr_i,
  .rdata_en_o, .pc_viol_o, .ca_viol_o, .wp_viol_o, .bus_conflict_o,
  .hot_cnt_o, .addr_lat
);

// File: tb/test_fram_model.sv
`timescale 1ns/1ps
module test_fram_model;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, clr_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        rdata_en_o, pc_viol_o, ca_viol_o, rc_viol_o, wp_viol_o, bus_conflict_o;
  logic [9:0]  hot_row_o;
  logic [7:0]  hot_cnt_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int row_cnt [1024];
  int hot_r = 0, hot_c = 0;

  always #2.5 clk_i = ~clk_i;

  fram_model i_fram_model (.*);

  // {write, addr, data}
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 13'h0000, 8'hA5}, {1'b1, 13'h0007, 8'h3C}, {1'b1, 13'h0008, 8'hC3},
    {1'b1, 13'h1FFF, 8'h7E}, {1'b1, 13'h1FF8, 8'h11},
    {1'b0, 13'h0000, 8'hA5}, {1'b0, 13'h0007, 8'h3C}, {1'b0, 13'h0008, 8'hC3},
    {1'b0, 13'h1FFF, 8'h7E}, {1'b0, 13'h1FF8, 8'h11}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bump(logic [12:0] a);
    int r = int'(a[12:3]);
    if (row_cnt[r] < 255) row_cnt[r]++;
    if (row_cnt[r] > hot_c) begin hot_c = row_cnt[r]; hot_r = r; end
  endtask

  task automatic flags(string req, logic [4:0] exp);
    chk(req, {pc_viol_o, ca_viol_o, rc_viol_o, wp_viol_o, bus_conflict_o}, exp);
  endtask

  task automatic clear();
    clr_i = 1'b1; tick(1); clr_i = 1'b0;
  endtask

  task automatic access(bit wr, logic [12:0] a, logic [7:0] d, int lo, int hi,
                        bit rchk, string req);
    ce_ni = 1'b0; addr_i = a; bump(a);
    if (wr) begin we_ni = 1'b0; wdata_i = d; end else oe_ni = 1'b0;
    tick(lo);
    if (rchk) begin
      chk(req, rdata_en_o, 1'b1);
      chk(req, rdata_o, d);
    end
    ce_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1;
    tick(hi);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (row_cnt[i]) row_cnt[i] = 0;
    tick(4); rst_ni = 1'b1; tick(2);
    // reset state R7
    flags("R7 reset flags", 5'b0);
    chk("R6 reset rdata_en", rdata_en_o, 1'b0);
    chk("R5 reset hot_cnt", hot_cnt_o, 0);

    // vector table: writes then reads at minimum legal timing
    for (int i = 0; i < 10; i++)
      access(VEC[i][21], VEC[i][20:8], VEC[i][7:0], 14, 12, !VEC[i][21], "R6 table read");
    flags("R2 R3 legal timing no flags", 5'b0);
    chk("R5 hot row", hot_row_o, hot_r);
    chk("R5 hot cnt", hot_cnt_o, hot_c);

    // R1: address changes after the falling edge are ignored (read)
    ce_ni = 1'b0; oe_ni = 1'b0; addr_i = 13'h0008; bump(13'h0008); tick(1);
    addr_i = 13'h0000; tick(13);
    chk("R1 read uses latched addr", rdata_o, 8'hC3);
    ce_ni = 1'b1; oe_ni = 1'b1; tick(12);
    // R1: write target latched at the fall
    ce_ni = 1'b0; we_ni = 1'b0; addr_i = 13'h0100; wdata_i = 8'h5A; bump(13'h0100); tick(1);
    addr_i = 13'h0007; tick(13);
    ce_ni = 1'b1; we_ni = 1'b1; tick(12);
    access(0, 13'h0100, 8'h5A, 14, 12, 1, "R1 write to latched addr");
    access(0, 13'h0007, 8'h3C, 14, 12, 1, "R1 other addr untouched");

    // R6: access delay, output-enable gating and release
    ce_ni = 1'b0; oe_ni = 1'b0; addr_i = 13'h0000; bump(13'h0000); tick(13);
    chk("R6 not before delay", rdata_en_o, 1'b0);
    chk("R6 rdata zero when idle", rdata_o, 8'h00);
    tick(1);
    chk("R6 valid at delay", rdata_en_o, 1'b1);
    oe_ni = 1'b1; tick(1);
    chk("R6 released on oe high", rdata_en_o, 1'b0);
    oe_ni = 1'b0; tick(1);
    chk("R6 back on oe low", rdata_o, 8'hA5);
    ce_ni = 1'b1; tick(1);
    chk("R6 released on ce high", rdata_en_o, 1'b0);
    oe_ni = 1'b1; tick(11);

    // R2/R3: precharge one sample short -> pc and rc
    clear();
    access(0, 13'h0200, 8'h00, 14, 11, 0, "");
    access(0, 13'h0200, 8'h00, 14, 12, 0, "");
    flags("R2 short precharge", 5'b10100);
    // R7 clear
    clear();
    flags("R7 clear", 5'b0);
    // R3: short low time -> ca only (cycle 10+16 = 26 ok)
    access(0, 13'h0200, 8'h00, 10, 16, 0, "");
    access(0, 13'h0200, 8'h00, 14, 12, 0, "");
    flags("R3 short active", 5'b01000);
    // R3: short low time with short cycle -> ca and rc
    clear();
    access(0, 13'h0200, 8'h00, 10, 12, 0, "");
    access(0, 13'h0200, 8'h00, 14, 12, 0, "");
    flags("R3 short cycle", 5'b01100);

    // R4: WE-controlled write, pulse exactly 8 samples: no flag, stored
    clear();
    ce_ni = 1'b0; addr_i = 13'h0300; bump(13'h0300); tick(2);
    we_ni = 1'b0; wdata_i = 8'h81; tick(8); we_ni = 1'b1; tick(4);
    ce_ni = 1'b1; tick(12);
    flags("R4 legal pulse", 5'b0);
    access(0, 13'h0300, 8'h81, 14, 12, 1, "R4 we-controlled write");
    // R4: 7-sample pulse flagged, still stored
    ce_ni = 1'b0; addr_i = 13'h0301; bump(13'h0301); tick(2);
    we_ni = 1'b0; wdata_i = 8'h92; tick(7); we_ni = 1'b1; tick(5);
    ce_ni = 1'b1; tick(12);
    flags("R4 short pulse", 5'b00010);
    access(0, 13'h0301, 8'h92, 14, 12, 1, "R4 short pulse write");
    // R4: CE-controlled write, WE rises last
    clear();
    we_ni = 1'b0; wdata_i = 8'h66; tick(2);
    ce_ni = 1'b0; addr_i = 13'h0302; bump(13'h0302); tick(14);
    ce_ni = 1'b1; tick(3); we_ni = 1'b1; tick(12);
    access(0, 13'h0302, 8'h66, 14, 12, 1, "R4 ce-controlled write");

    // R9: write and output enable together
    clear();
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b0; addr_i = 13'h0303; wdata_i = 8'hE7;
    bump(13'h0303); tick(14);
    chk("R9 no read during conflict", rdata_en_o, 1'b0);
    ce_ni = 1'b1; oe_ni = 1'b1; we_ni = 1'b1; tick(12);
    flags("R9 conflict flag", 5'b00001);
    access(0, 13'h0303, 8'hE7, 14, 12, 1, "R9 write wins");

    // R5/R8: hammer one row past saturation
    for (int i = 0; i < 300; i++)
      access(0, 13'h0280 | 13'(i % 8), 8'h00, 14, 12, 0, "");
    chk("R8 saturated count", hot_cnt_o, 8'd255);
    chk("R5 hot row index", hot_row_o, 10'h050);
    chk("R5 hot row model", hot_row_o, hot_r);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule